// File: doc/BRIEF.md
# Register-Controlled User I/O Panel

This block sits on a small register bus and drives a front panel of indicators: a left and a right 7-segment display, each with a decimal point, four red LEDs, four green LEDs, and a red/green status LED pair for each of two radio channels. Every one of these output bits can be driven either by a register that software writes or by a hardware input from neighbouring user logic. A control register picks the source for each group of outputs. Software can change it at any moment and needs no start-up sequence.

When a display is driven from its software register, it can optionally convert the low four bits of that register into the segment pattern of a hexadecimal digit. The hardware path to a display always carries raw segments. The block also debounces a four-position switch bank and three push buttons. The clean values are readable over the bus and are also driven on output ports for user logic.

The bus is a plain synchronous interface: a write strobe with an address and data, and a read data port that follows the address combinationally. Data is 8 bits wide and addresses are 3 bits wide.

Top module: `uio_panel`

## Requirements
- R1: After reset the control register reads 0x64, so only the radio LEDs are under hardware control and hex mapping is on for both displays. The data registers read 0 and the debounced inputs read 0.
- R2: The control register at address 0 is read/write. Bit 0 selects hardware for the red LEDs, bit 1 for the green LEDs, bit 2 for the radio LEDs, bit 3 for the left display and bit 4 for the right display. Bit 5 is the left map mode and bit 6 the right map mode. Bit 7 always reads 0.
- R3: With a group's select bit at 0, each output bit of that group equals its software register bit, and the hardware input is ignored. The software registers sit at these addresses: red LEDs at 1 (bits 3:0), green LEDs at 2, and radio LEDs at 3. In the radio register, bit 0 is channel A red, bit 1 channel A green, bit 2 channel B red and bit 3 channel B green.
- R4: With a group's select bit at 1, each output bit of that group follows its hardware input in the same cycle, and the software register is ignored.
- R5: Each select field switches only its own group; the other groups keep their source.
- R6: A display under software control with map mode set shows the hex digit of register bits 3:0, with segment a on bit 0 through segment g on bit 6. Bits 6:4 of the register have no effect. The patterns for 0 to F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.
- R7: A display under software control with map mode clear drives register bits 6:0 directly onto the segments. The left display register is at address 4 and the right one at address 5.
- R8: A display under hardware control drives its hardware segment input unchanged, whatever the map mode.
- R9: A decimal point takes bit 7 of its display register under software control, or its hardware input under hardware control. Map mode never alters it.
- R10: A debounced input changes only after its two-flop synchronized value has differed from it for DEBOUNCE_CYCLES consecutive clocks. The output updates on the (DEBOUNCE_CYCLES+2)th edge after the raw change. Shorter pulses are ignored.
- R11: The debounced values read at address 6, with the switches on bits 3:0 and the up, middle and down buttons on bits 4, 5 and 6. The same values drive the clean output ports.
- R12: Address 7 reads 0. Writes to address 6 or 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wen | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| hw_red | input | 4 | Hardware source, red LEDs |
| hw_green | input | 4 | Hardware source, green LEDs |
| hw_radio | input | 4 | Hardware source, radio LEDs |
| hw_seg_left | input | 7 | Hardware segments, left display |
| hw_dp_left | input | 1 | Hardware decimal point, left |
| hw_seg_right | input | 7 | Hardware segments, right display |
| hw_dp_right | input | 1 | Hardware decimal point, right |
| led_red | output | 4 | Red LED drive |
| led_green | output | 4 | Green LED drive |
| led_radio | output | 4 | Radio status LED drive |
| seg_left | output | 7 | Left display segments |
| dp_left | output | 1 | Left decimal point |
| seg_right | output | 7 | Right display segments |
| dp_right | output | 1 | Right decimal point |
| sw_raw | input | 4 | Raw switch bank |
| btn_raw | input | 3 | Raw buttons: up, middle, down |
| sw_clean | output | 4 | Debounced switches |
| btn_clean | output | 3 | Debounced buttons |

## Verification
On every cycle the assertions check four things. An output group under software control stays still unless its register or its select bit changes. A display under hardware control moves only with its hardware input. A mapped display ignores register bits 6:4. A debounced output changes only on a full stability count, and only to the synchronized value. The bench covers the rest through sweeps: the reset value, every register value on both paths, the exact hex patterns, the decimal point, and the isolation of each select field. It also measures the debounce delay to the cycle, tries a pulse that is too short, and probes the read-only and unmapped addresses.

// File: rtl/uio_pkg.sv
package uio_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  localparam logic [AW-1:0] A_CTRL   = 3'd0;
  localparam logic [AW-1:0] A_RED    = 3'd1;
  localparam logic [AW-1:0] A_GREEN  = 3'd2;
  localparam logic [AW-1:0] A_RADIO  = 3'd3;
  localparam logic [AW-1:0] A_LEFT   = 3'd4;
  localparam logic [AW-1:0] A_RIGHT  = 3'd5;
  localparam logic [AW-1:0] A_INPUTS = 3'd6;

  typedef struct packed {
    logic map_right;
    logic map_left;
    logic hw_right;
    logic hw_left;
    logic hw_radio;
    logic hw_green;
    logic hw_red;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = 7'h64;

  // hex digit to segments, a on bit 0 .. g on bit 6, active high
  function automatic logic [6:0] hex_to_seg(input logic [3:0] d);
    logic [6:0] s;
    case (d)
      4'h0: s = 7'h3F;
      4'h1: s = 7'h06;
      4'h2: s = 7'h5B;
      4'h3: s = 7'h4F;
      4'h4: s = 7'h66;
      4'h5: s = 7'h6D;
      4'h6: s = 7'h7D;
      4'h7: s = 7'h07;
      4'h8: s = 7'h7F;
      4'h9: s = 7'h6F;
      4'hA: s = 7'h77;
      4'hB: s = 7'h7C;
      4'hC: s = 7'h39;
      4'hD: s = 7'h5E;
      4'hE: s = 7'h79;
      default: s = 7'h71;
    endcase
    return s;
  endfunction

  // software display path: mapped digit or raw segments
  function automatic logic [6:0] sw_segments(input logic [6:0] v, input logic map_en);
    return map_en ? hex_to_seg(v[3:0]) : v;
  endfunction
endpackage

// File: rtl/uio_debounce.sv
module uio_debounce #(
  parameter int DEBOUNCE_CYCLES = 65536
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(DEBOUNCE_CYCLES) + 1;
  localparam logic [CW-1:0] LIMIT = CW'(DEBOUNCE_CYCLES - 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;
  logic          differs;
  logic          upd;

  assign differs = (s2 != clean);
  assign upd     = differs && (cnt == LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      cnt   <= '0;
      clean <= 1'b0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (!differs) begin
        cnt <= '0;
      end else if (upd) begin
        cnt   <= '0;
        clean <= s2;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_DB_ONLY_ON_FULL: assert property (@(posedge clk) disable iff (rst)
    !$stable(clean) |-> $past(upd)) else $error("debounce moved early"); // R10
  AST_DB_TAKES_SYNC: assert property (@(posedge clk) disable iff (rst)
    !$stable(clean) |-> (clean == $past(s2))) else $error("debounce wrong value"); // R10
endmodule

// File: rtl/uio_srcmux.sv
module uio_srcmux #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel_hw,
  input  logic [W-1:0] sw_val,
  input  logic [W-1:0] hw_val,
  output logic [W-1:0] out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign out[i] = sel_hw ? hw_val[i] : sw_val[i];
  end

  AST_SW_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!sel_hw && !$past(sel_hw) && $stable(sw_val)) |-> $stable(out))
    else $error("software path moved with hw input"); // R3
  AST_HW_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (sel_hw && $past(sel_hw) && $stable(hw_val)) |-> $stable(out))
    else $error("hardware path moved with register"); // R4
endmodule

// File: rtl/uio_regs.sv
module uio_regs
  import uio_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wen,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [6:0]    inputs_clean,
  output ctrl_t         ctrl,
  output logic [3:0]    red_q,
  output logic [3:0]    green_q,
  output logic [3:0]    radio_q,
  output logic [7:0]    left_q,
  output logic [7:0]    right_q
);
  logic wr_ctrl, wr_red, wr_green, wr_radio, wr_left, wr_right;
  logic wr_nomap;

  assign wr_ctrl  = bus_wen && (bus_addr == A_CTRL);
  assign wr_red   = bus_wen && (bus_addr == A_RED);
  assign wr_green = bus_wen && (bus_addr == A_GREEN);
  assign wr_radio = bus_wen && (bus_addr == A_RADIO);
  assign wr_left  = bus_wen && (bus_addr == A_LEFT);
  assign wr_right = bus_wen && (bus_addr == A_RIGHT);
  assign wr_nomap = bus_wen && (bus_addr >= A_INPUTS);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= CTRL_RST;
      red_q   <= '0;
      green_q <= '0;
      radio_q <= '0;
      left_q  <= '0;
      right_q <= '0;
    end else begin
      if (wr_ctrl)  ctrl    <= ctrl_t'(bus_wdata[6:0]);
      if (wr_red)   red_q   <= bus_wdata[3:0];
      if (wr_green) green_q <= bus_wdata[3:0];
      if (wr_radio) radio_q <= bus_wdata[3:0];
      if (wr_left)  left_q  <= bus_wdata;
      if (wr_right) right_q <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:   bus_rdata = {1'b0, ctrl};
      A_RED:    bus_rdata = {4'b0, red_q};
      A_GREEN:  bus_rdata = {4'b0, green_q};
      A_RADIO:  bus_rdata = {4'b0, radio_q};
      A_LEFT:   bus_rdata = left_q;
      A_RIGHT:  bus_rdata = right_q;
      A_INPUTS: bus_rdata = {1'b0, inputs_clean};
      default:  bus_rdata = '0;
    endcase
  end

  AST_RO_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    $past(wr_nomap) |-> ($stable(ctrl) && $stable(red_q) && $stable(green_q) &&
                         $stable(radio_q) && $stable(left_q) && $stable(right_q)))
    else $error("write to read-only space changed state"); // R12
  AST_CTRL_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A_CTRL) |-> (bus_rdata[7] == 1'b0))
    else $error("control bit 7 nonzero"); // R2
endmodule

// File: rtl/uio_panel.sv
module uio_panel
  import uio_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 65536,
  parameter int N_SW            = 4,
  parameter int N_BTN           = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wen,
  input  logic [2:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [3:0]       hw_red,
  input  logic [3:0]       hw_green,
  input  logic [3:0]       hw_radio,
  input  logic [6:0]       hw_seg_left,
  input  logic             hw_dp_left,
  input  logic [6:0]       hw_seg_right,
  input  logic             hw_dp_right,
  output logic [3:0]       led_red,
  output logic [3:0]       led_green,
  output logic [3:0]       led_radio,
  output logic [6:0]       seg_left,
  output logic             dp_left,
  output logic [6:0]       seg_right,
  output logic             dp_right,
  input  logic [N_SW-1:0]  sw_raw,
  input  logic [N_BTN-1:0] btn_raw,
  output logic [N_SW-1:0]  sw_clean,
  output logic [N_BTN-1:0] btn_clean
);
  localparam int N_IN = N_SW + N_BTN;

  ctrl_t       ctrl;
  logic [3:0]  red_q, green_q, radio_q;
  logic [7:0]  left_q, right_q;
  logic [6:0]  inputs_clean;
  logic [N_IN-1:0] raw_all, clean_all;
  logic [7:0]  left_sw, right_sw;
  logic [7:0]  left_out, right_out;

  assign raw_all   = {btn_raw, sw_raw};
  assign sw_clean  = clean_all[N_SW-1:0];
  assign btn_clean = clean_all[N_IN-1:N_SW];
  assign inputs_clean = 7'(clean_all);

  for (genvar i = 0; i < N_IN; i++) begin : g_db
    uio_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_db (
      .clk(clk), .rst(rst), .raw(raw_all[i]), .clean(clean_all[i])
    );
  end

  uio_regs u_regs (
    .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .inputs_clean(inputs_clean),
    .ctrl(ctrl), .red_q(red_q), .green_q(green_q), .radio_q(radio_q),
    .left_q(left_q), .right_q(right_q)
  );

  assign left_sw  = {left_q[7],  sw_segments(left_q[6:0],  ctrl.map_left)};
  assign right_sw = {right_q[7], sw_segments(right_q[6:0], ctrl.map_right)};

  uio_srcmux #(.W(4)) u_mux_red (
    .clk(clk), .rst(rst), .sel_hw(ctrl.hw_red), .sw_val(red_q),
    .hw_val(hw_red), .out(led_red));
  uio_srcmux #(.W(4)) u_mux_green (
    .clk(clk), .rst(rst), .sel_hw(ctrl.hw_green), .sw_val(green_q),
    .hw_val(hw_green), .out(led_green));
  uio_srcmux #(.W(4)) u_mux_radio (
    .clk(clk), .rst(rst), .sel_hw(ctrl.hw_radio), .sw_val(radio_q),
    .hw_val(hw_radio), .out(led_radio));
  uio_srcmux #(.W(8)) u_mux_left (
    .clk(clk), .rst(rst), .sel_hw(ctrl.hw_left), .sw_val(left_sw),
    .hw_val({hw_dp_left, hw_seg_left}), .out(left_out));
  uio_srcmux #(.W(8)) u_mux_right (
    .clk(clk), .rst(rst), .sel_hw(ctrl.hw_right), .sw_val(right_sw),
    .hw_val({hw_dp_right, hw_seg_right}), .out(right_out));

  assign seg_left  = left_out[6:0];
  assign dp_left   = left_out[7];
  assign seg_right = right_out[6:0];
  assign dp_right  = right_out[7];

  AST_MAP_IGNORES_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.hw_left && ctrl.map_left && $stable(ctrl) && $stable(left_q[3:0]) &&
     $stable(left_q[7])) |-> ($stable(seg_left) && $stable(dp_left)))
    else $error("mapped display reacted to upper bits"); // R6
  AST_HW_DISPLAY_RAW: assert property (@(posedge clk) disable iff (rst)
    (ctrl.hw_right && $stable(ctrl.hw_right) && $stable(hw_seg_right)) |-> $stable(seg_right))
    else $error("hardware display path not raw"); // R8
endmodule

// File: tb/uio_panel_tb.sv
module uio_panel_tb;
  localparam int DB = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wen = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] hw_red = '0, hw_green = '0, hw_radio = '0;
  logic [6:0] hw_seg_left = '0, hw_seg_right = '0;
  logic hw_dp_left = 1'b0, hw_dp_right = 1'b0;
  logic [3:0] led_red, led_green, led_radio;
  logic [6:0] seg_left, seg_right;
  logic dp_left, dp_right;
  logic [3:0] sw_raw = '0;
  logic [2:0] btn_raw = '0;
  logic [3:0] sw_clean;
  logic [2:0] btn_clean;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uio_panel #(.DEBOUNCE_CYCLES(DB)) u_dut (
    .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_red(hw_red),
    .hw_green(hw_green), .hw_radio(hw_radio), .hw_seg_left(hw_seg_left),
    .hw_dp_left(hw_dp_left), .hw_seg_right(hw_seg_right), .hw_dp_right(hw_dp_right),
    .led_red(led_red), .led_green(led_green), .led_radio(led_radio),
    .seg_left(seg_left), .dp_left(dp_left), .seg_right(seg_right),
    .dp_right(dp_right), .sw_raw(sw_raw), .btn_raw(btn_raw),
    .sw_clean(sw_clean), .btn_clean(btn_clean));

  // digits F down to 0, seven bits each
  localparam logic [111:0] DIGITS = {
    7'h71, 7'h79, 7'h5E, 7'h39, 7'h7C, 7'h77, 7'h6F, 7'h7F,
    7'h07, 7'h7D, 7'h6D, 7'h66, 7'h4F, 7'h5B, 7'h06, 7'h3F};

  function automatic logic [6:0] digit(input int v);
    return DIGITS[(v % 16) * 7 +: 7];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, r); check("R1 ctrl", r, 8'h64);
    for (int a = 1; a <= 6; a++) begin
      rd(3'(a), r); check("R1 reg zero", r, 0);
    end
    hw_radio = 4'h5; #1;
    check("R1 radio hw after reset", led_radio, 4'h5);
    check("R1 red sw after reset", led_red, 0);
    check("R1 left mapped zero", seg_left, 7'h3F);

    // R2 control readback and read-modify-write
    wr(3'd0, 8'hFF); rd(3'd0, r); check("R2 ctrl bit7 zero", r, 8'h7F);
    wr(3'd0, 8'h60); rd(3'd0, r); wr(3'd0, r | 8'h02); rd(3'd0, r);
    check("R2 rmw", r, 8'h62);
    wr(3'd0, 8'h60);

    // R3 software path ignores hardware
    for (int v = 0; v < 16; v++) begin
      hw_red = ~4'(v); hw_green = 4'(v + 3); hw_radio = 4'(v ^ 9);
      wr(3'd1, 8'(v)); wr(3'd2, 8'(15 - v)); wr(3'd3, 8'(v ^ 5));
      check("R3 red", led_red, v);
      check("R3 green", led_green, 15 - v);
      check("R3 radio", led_radio, v ^ 5);
    end

    // R4 and R5 per-group selection
    wr(3'd1, 8'h0A); wr(3'd2, 8'h0C); wr(3'd3, 8'h03);
    for (int g = 0; g < 3; g++) begin
      wr(3'd0, 8'(8'h60 | (1 << g)));
      for (int v = 0; v < 16; v++) begin
        @(negedge clk);
        hw_red = 4'(v); hw_green = 4'(v ^ 6); hw_radio = 4'(15 - v); #1;
        check(g == 0 ? "R4 red hw" : "R5 red stays sw", led_red, g == 0 ? v : 8'h0A);
        check(g == 1 ? "R4 green hw" : "R5 green stays sw", led_green, g == 1 ? (v ^ 6) : 8'h0C);
        check(g == 2 ? "R4 radio hw" : "R5 radio stays sw", led_radio, g == 2 ? (15 - v) : 8'h03);
      end
    end

    // R6 and R9 mapped displays over all register values
    wr(3'd0, 8'h60);
    hw_seg_left = 7'h55; hw_seg_right = 7'h2A; hw_dp_left = 1'b1; hw_dp_right = 1'b1;
    for (int v = 0; v < 256; v++) begin
      wr(3'd4, 8'(v)); wr(3'd5, 8'(255 - v));
      check("R6 left map", seg_left, digit(v % 16));
      check("R6 right map", seg_right, digit((255 - v) % 16));
      check("R9 left dp", dp_left, v / 128);
      check("R9 right dp", dp_right, (255 - v) / 128);
    end

    // R7 raw software segments
    wr(3'd0, 8'h00);
    for (int v = 0; v < 128; v++) begin
      wr(3'd4, 8'(v)); wr(3'd5, 8'(v ^ 8'h5A));
      check("R7 left raw", seg_left, v);
      check("R7 right raw", seg_right, (v ^ 8'h5A) & 8'h7F);
    end

    // R8 hardware display path ignores map mode
    wr(3'd4, 8'h03); wr(3'd5, 8'h04);
    for (int m = 0; m < 2; m++) begin
      wr(3'd0, m ? 8'h78 : 8'h18);
      for (int v = 0; v < 128; v++) begin
        @(negedge clk);
        hw_seg_left = 7'(v); hw_seg_right = 7'(127 - v); hw_dp_left = v[0]; hw_dp_right = v[1]; #1;
        check("R8 left hw", seg_left, v);
        check("R8 right hw", seg_right, 127 - v);
        check("R9 left hw dp", dp_left, v % 2);
        check("R9 right hw dp", dp_right, (v / 2) % 2);
      end
    end

    // R12 unmapped and read-only addresses
    wr(3'd0, 8'h21); wr(3'd1, 8'h09);
    wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    rd(3'd7, r); check("R12 unmapped read", r, 0);
    rd(3'd6, r); check("R12 inputs not writable", r, 0);
    rd(3'd0, r); check("R12 ctrl untouched", r, 8'h21);
    rd(3'd1, r); check("R12 red untouched", r, 8'h09);

    // R10 and R11 debounce timing
    @(negedge clk);
    sw_raw = 4'hA; btn_raw = 3'b101;
    repeat (DB + 1) @(negedge clk);
    check("R10 switch not yet", sw_clean, 0);
    @(negedge clk);
    check("R10 switch updated", sw_clean, 4'hA);
    check("R11 buttons port", btn_clean, 3'b101);
    rd(3'd6, r); check("R11 inputs register", r, 8'h5A);

    // R10 short pulse ignored
    @(negedge clk);
    sw_raw = 4'h5; btn_raw = 3'b010;
    repeat (DB - 2) @(negedge clk);
    sw_raw = 4'hA; btn_raw = 3'b101;
    repeat (3 * DB) @(negedge clk);
    check("R10 glitch switch", sw_clean, 4'hA);
    check("R10 glitch button", btn_clean, 3'b101);

    // R11 release
    sw_raw = 4'h3; btn_raw = 3'b010;
    repeat (DB + 4) @(negedge clk);
    rd(3'd6, r); check("R11 inputs after change", r, 8'h23);
    check("R11 switch port", sw_clean, 4'h3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule